// File: doc/BRIEF.md
# DDR sample word de-interleaver

This block sits behind the receive pins of a dual-channel 16-bit sampling converter. The converter sends each sample word on eight data lanes per channel, two bits per lane per clock period, together with a forwarded clock that runs at the sample rate. On each lane, the odd-numbered bit of a word is present at the falling edge of the forwarded clock. The even-numbered bit of the same word follows at the next rising edge. The block captures the odd half on the falling edge and joins it with the even half at the rising edge. It then presents one complete word per channel per forwarded clock cycle, with a shared valid strobe.

Incoming codes are offset binary. With format conversion selected, the block returns two's complement words by flipping the most significant bit. Range flags mark the all-ones and all-zeros codes in every format. The converter parks its clock and all data lines low while it calibrates. A small detector, clocked by a free-running monitor clock that is faster than the forwarded clock, recognises that quiet period. The word built at the first rising edge after the clock comes back pairs with an odd half from before the stop, so the block withholds the valid strobe for that word.

Top module: `ddr_sample_rebuilder`

## Requirements
- R1: Lane k of a channel supplies word bit 2k+1 from its level at a falling edge of `fwd_clk`, and word bit 2k from its level at the following rising edge. The completed word appears on `sample_word` just after that rising edge and holds until the next rising edge.
- R2: Channel I uses `lanes[7:0]` and is output on `sample_word[15:0]`. Channel Q uses `lanes[15:8]` and is output on `sample_word[31:16]`. Both channels are assembled on the same edges, and neither affects the other.
- R3: With `twos_comp_en` low at the completing rising edge, the output word equals the received offset-binary code. With it high, the output word is the received code with bit 15 inverted.
- R4: `over_range[c]` is high exactly when the received code of channel c is 16'hFFFF. `under_range[c]` is high exactly when the received code is 16'h0000. Both flags ignore `twos_comp_en`, and they are never high together.
- R5: While the forwarded clock runs, `sample_valid` is high after every completing rising edge, so that one word per channel is delivered per clock cycle.
- R6: Reset is synchronous and active low. While reset is applied, `sample_word`, both flag vectors and `sample_valid` are zero. After release, `sample_valid` stays low until a falling edge has captured an odd half out of reset.
- R7: `cal_idle` rises after `fwd_clk` and every lane have been seen low, after a two-stage synchronizer, for 16 consecutive `mon_clk` cycles. Any high lane or a running clock keeps it low. It falls within three `mon_clk` cycles after activity returns.
- R8: The word completed at a rising edge where `cal_idle` is high has `sample_valid` low. When `mon_clk` is at least four times faster than `fwd_clk`, the next word is delivered with `sample_valid` high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fwd_clk | input | 1 | Forwarded clock from the converter, one period per sample |
| mon_clk | input | 1 | Free-running monitor clock for the calibration detector, faster than fwd_clk |
| rst_n | input | 1 | Synchronous active-low reset, sampled in both clock domains |
| twos_comp_en | input | 1 | 1: output two's complement; 0: output offset binary |
| lanes | input | 16 | DDR data lanes: [7:0] channel I, [15:8] channel Q |
| sample_word | output | 32 | Assembled words: [15:0] channel I, [31:16] channel Q |
| sample_valid | output | 1 | High for each cycle that carries a complete, trustworthy word |
| over_range | output | 2 | Per-channel flag for received code all ones |
| under_range | output | 2 | Per-channel flag for received code all zeros |
| cal_idle | output | 1 | Calibration quiet period detected (monitor clock domain) |

## Verification
The main stream is driven with bit patterns that isolate each failure mode. Alternating 0xAAAA and 0x5555 codes catch a swap of the odd and even halves. A single set bit at either end of the word catches reversed lane order. Different I and Q codes in the same cycle catch crossed channels. The two extreme codes are sent in both formats, so the flags are shown to follow the received code and not the converted one, while mid-scale codes 0x7FFF and 0x8000 expose a wrong MSB flip. The stopped-clock tests hold one lane high before letting all lanes fall, which checks that lane activity blocks calibration detection. They then resume the clock to separate the suppressed first word from the valid second one.

// File: rtl/ddr_deint_pkg.sv
`timescale 1ns/1ps
// Shared types for the DDR sample word de-interleaver.
package ddr_deint_pkg;

    // Output number format selected per completing edge.
    typedef enum logic {
        FMT_OFFSET_BIN = 1'b0,
        FMT_TWOS_COMP  = 1'b1
    } word_fmt_e;

    // Range indication derived from the received offset-binary code.
    typedef struct packed {
        logic over;
        logic under;
    } range_flags_t;

endpackage

// File: rtl/ddr_half_capture.sv
`timescale 1ns/1ps
// ddr_half_capture
// Holds the odd half of one channel's word, captured on the falling edge of
// the forwarded clock. Places it beside the live even half, so the rising edge
// downstream sees a full word.
// Assumes: lane k carries word bits 2k+1 (falling edge) and 2k (rising edge).
module ddr_half_capture #(
    parameter int LANES = 8,
    localparam int WORD_W = 2 * LANES
) (
    input  logic              fwd_clk,
    input  logic              rst_n,
    input  logic [LANES-1:0]  lanes,
    output logic [WORD_W-1:0] word_now
);

    logic [LANES-1:0] odd_q;

    // Store the odd bits present at each falling edge.
    always_ff @(negedge fwd_clk) begin
        if (!rst_n) begin
            odd_q <= '0;
        end else begin
            odd_q <= lanes;
        end
    end

    // Interleave the stored odd bits with the even bits on the lanes now.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign word_now[2*k+1] = odd_q[k];
        assign word_now[2*k]   = lanes[k];
    end

endmodule

// File: rtl/word_formatter.sv
`timescale 1ns/1ps
// word_formatter
// Converts an assembled offset-binary word to the selected output format and
// derives the range flags from the received code.
// Assumes: incoming codes are offset binary; purely combinational.
module word_formatter
    import ddr_deint_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] raw_word,
    input  word_fmt_e         fmt,
    output logic [WORD_W-1:0] word_out,
    output range_flags_t      flags
);

    localparam logic [WORD_W-1:0] MSB_MASK = {1'b1, {(WORD_W-1){1'b0}}};

    // Flip the sign bit when two's complement output is requested.
    always_comb begin
        word_out = (fmt == FMT_TWOS_COMP) ? (raw_word ^ MSB_MASK) : raw_word;
    end

    // Flag the extreme codes of the received offset-binary word.
    always_comb begin
        flags.over  = &raw_word;
        flags.under = ~|raw_word;
    end

endmodule

// File: rtl/cal_idle_detect.sv
`timescale 1ns/1ps
// cal_idle_detect
// Watches the forwarded clock level and every data lane from a free-running
// monitor clock. Reports a calibration quiet period once all of them have
// stayed low for IDLE_CYCLES synchronized samples.
// Assumes: mon_clk is faster than fwd_clk, so a running clock always shows a
// high sample well within IDLE_CYCLES.
module cal_idle_detect #(
    parameter int SIG_W       = 16,
    parameter int IDLE_CYCLES = 16,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(IDLE_CYCLES + 1)
) (
    input  logic             mon_clk,
    input  logic             rst_n,
    input  logic             fwd_level,
    input  logic [SIG_W-1:0] lanes,
    output logic             cal_idle
);

    logic [SYNC_STAGES-1:0][SIG_W:0] sync_q;
    logic [CNT_W-1:0]                quiet_cnt;
    logic                            activity;

    // Bring the clock level and lanes into the monitor domain.
    always_ff @(posedge mon_clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q[0] <= {fwd_level, lanes};
            for (int s = 1; s < SYNC_STAGES; s++) begin
                sync_q[s] <= sync_q[s-1];
            end
        end
    end

    assign activity = |sync_q[SYNC_STAGES-1];

    // Count quiet samples; raise the flag at the limit, drop it on activity.
    always_ff @(posedge mon_clk) begin
        if (!rst_n) begin
            quiet_cnt <= '0;
            cal_idle  <= 1'b0;
        end else if (activity) begin
            quiet_cnt <= '0;
            cal_idle  <= 1'b0;
        end else if (quiet_cnt == CNT_W'(IDLE_CYCLES - 1)) begin
            cal_idle  <= 1'b1;
        end else begin
            quiet_cnt <= quiet_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/ddr_sample_rebuilder.sv
`timescale 1ns/1ps
// ddr_sample_rebuilder
// Rebuilds full sample words for each converter channel from DDR lanes. Odd
// halves are taken at the falling edge and even halves at the following
// rising edge. Words, range flags and a valid strobe are registered on the
// rising edge. A monitor-domain detector flags the calibration quiet period.
// The first word after the clock resumes is marked invalid.
// Assumes: rst_n is synchronous to both clocks; cal_idle is stable at the
// first rising edge after a stop because it only clears after the monitor
// has seen that edge.
module ddr_sample_rebuilder
    import ddr_deint_pkg::*;
#(
    parameter int LANES       = 8,
    parameter int CHANNELS    = 2,
    parameter int IDLE_CYCLES = 16,
    parameter int SYNC_STAGES = 2,
    localparam int WORD_W     = 2 * LANES,
    localparam int BUS_W      = CHANNELS * LANES,
    localparam int OUT_W      = CHANNELS * WORD_W
) (
    input  logic                fwd_clk,
    input  logic                mon_clk,
    input  logic                rst_n,
    input  logic                twos_comp_en,
    input  logic [BUS_W-1:0]    lanes,
    output logic [OUT_W-1:0]    sample_word,
    output logic                sample_valid,
    output logic [CHANNELS-1:0] over_range,
    output logic [CHANNELS-1:0] under_range,
    output logic                cal_idle
);

    word_fmt_e fmt_sel;
    logic      odd_loaded;
    logic      valid_q;

    assign fmt_sel = twos_comp_en ? FMT_TWOS_COMP : FMT_OFFSET_BIN;

    // Record that an odd half has been captured since reset.
    always_ff @(negedge fwd_clk) begin
        if (!rst_n) begin
            odd_loaded <= 1'b0;
        end else begin
            odd_loaded <= 1'b1;
        end
    end

    // Per-channel capture, format and output registers.
    for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
        logic [WORD_W-1:0] raw_w;
        logic [WORD_W-1:0] fmt_w;
        logic [WORD_W-1:0] word_q;
        range_flags_t      rng_w;
        range_flags_t      rng_q;

        ddr_half_capture #(
            .LANES(LANES)
        ) u_cap (
            .fwd_clk (fwd_clk),
            .rst_n   (rst_n),
            .lanes   (lanes[c*LANES +: LANES]),
            .word_now(raw_w)
        );

        word_formatter #(
            .WORD_W(WORD_W)
        ) u_fmt (
            .raw_word(raw_w),
            .fmt     (fmt_sel),
            .word_out(fmt_w),
            .flags   (rng_w)
        );

        // Register the completed word and its flags on the rising edge.
        always_ff @(posedge fwd_clk) begin
            if (!rst_n) begin
                word_q <= '0;
                rng_q  <= '0;
            end else begin
                word_q <= fmt_w;
                rng_q  <= rng_w;
            end
        end

        assign sample_word[c*WORD_W +: WORD_W] = word_q;
        assign over_range[c]                   = rng_q.over;
        assign under_range[c]                  = rng_q.under;
    end

    // Mark the word valid unless its odd half is stale or missing.
    always_ff @(posedge fwd_clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else begin
            valid_q <= odd_loaded & ~cal_idle;
        end
    end

    assign sample_valid = valid_q;

    cal_idle_detect #(
        .SIG_W      (BUS_W),
        .IDLE_CYCLES(IDLE_CYCLES),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_cal (
        .mon_clk  (mon_clk),
        .rst_n    (rst_n),
        .fwd_level(fwd_clk),
        .lanes    (lanes),
        .cal_idle (cal_idle)
    );

endmodule

// File: rtl/ddr_sample_rebuilder_chk.sv
`timescale 1ns/1ps
// ddr_sample_rebuilder_chk
// Port-level properties of the de-interleaver, bound to every instance.
module ddr_sample_rebuilder_chk #(
    parameter int LANES    = 8,
    parameter int CHANNELS = 2,
    localparam int WORD_W  = 2 * LANES,
    localparam int OUT_W   = CHANNELS * WORD_W
) (
    input logic                fwd_clk,
    input logic                rst_n,
    input logic                twos_comp_en,
    input logic [OUT_W-1:0]    sample_word,
    input logic                sample_valid,
    input logic [CHANNELS-1:0] over_range,
    input logic [CHANNELS-1:0] under_range,
    input logic                cal_idle
);

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge fwd_clk) disable iff (!rst_n)
        (over_range & under_range) == '0) else $error("range flags both high"); // R4

    AST_VALID_AFTER_RESET: assert property (@(posedge fwd_clk) disable iff (!rst_n)
        sample_valid |-> $past(rst_n)) else $error("valid without prior run"); // R6

    AST_RESUME_SUPPRESS: assert property (@(posedge fwd_clk) disable iff (!rst_n)
        cal_idle |=> !sample_valid) else $error("stale word marked valid"); // R8

    for (genvar c = 0; c < CHANNELS; c++) begin : g_chk
        AST_OVER_ALL_ONES: assert property (@(posedge fwd_clk) disable iff (!rst_n)
            over_range[c] |-> ((sample_word[c*WORD_W +: WORD_W]
                ^ {$past(twos_comp_en), {(WORD_W-1){1'b0}}}) == {WORD_W{1'b1}}))
            else $error("over flag on non-full code"); // R4

        AST_UNDER_ALL_ZEROS: assert property (@(posedge fwd_clk) disable iff (!rst_n)
            under_range[c] |-> ((sample_word[c*WORD_W +: WORD_W]
                ^ {$past(twos_comp_en), {(WORD_W-1){1'b0}}}) == {WORD_W{1'b0}}))
            else $error("under flag on non-zero code"); // R4
    end

endmodule

bind ddr_sample_rebuilder ddr_sample_rebuilder_chk #(
    .LANES   (LANES),
    .CHANNELS(CHANNELS)
) u_chk (
    .fwd_clk     (fwd_clk),
    .rst_n       (rst_n),
    .twos_comp_en(twos_comp_en),
    .sample_word (sample_word),
    .sample_valid(sample_valid),
    .over_range  (over_range),
    .under_range (under_range),
    .cal_idle    (cal_idle)
);

// File: tb/ddr_sample_rebuilder_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: a DDR lane model drives known word pairs, then
// directed tests cover reset, the calibration stop and the resume.
module ddr_sample_rebuilder_tb_top;

    localparam int LANES = 8;
    localparam int CH    = 2;
    localparam int W     = 2 * LANES;
    localparam int NVEC  = 10;

    // Vector layout: {twos_comp_en, Q code, I code}, codes in offset binary.
    localparam logic [2*W:0] VEC [NVEC] = '{
        {1'b0, 16'h5555, 16'hAAAA},
        {1'b0, 16'h0001, 16'h8000},
        {1'b0, 16'hFFFF, 16'h0000},
        {1'b1, 16'hFFFF, 16'h0000},
        {1'b1, 16'h8000, 16'h7FFF},
        {1'b0, 16'h1234, 16'hFEDC},
        {1'b1, 16'h00FF, 16'hFF00},
        {1'b0, 16'h0F0F, 16'hC3C3},
        {1'b1, 16'h0000, 16'hFFFF},
        {1'b0, 16'h8001, 16'h4002}
    };

    logic          fwd_clk = 1'b0;
    logic          mon_clk = 1'b0;
    logic          rst_n   = 1'b0;
    logic          twos_comp_en = 1'b0;
    logic [CH*LANES-1:0] lanes = '0;
    logic [CH*W-1:0]     sample_word;
    logic                sample_valid;
    logic [CH-1:0]       over_range;
    logic [CH-1:0]       under_range;
    logic                cal_idle;

    logic clk_run = 1'b1;
    bit   done    = 1'b0;
    int   n_checks = 0;
    int   n_err    = 0;

    ddr_sample_rebuilder dut_i (
        .fwd_clk     (fwd_clk),
        .mon_clk     (mon_clk),
        .rst_n       (rst_n),
        .twos_comp_en(twos_comp_en),
        .lanes       (lanes),
        .sample_word (sample_word),
        .sample_valid(sample_valid),
        .over_range  (over_range),
        .under_range (under_range),
        .cal_idle    (cal_idle)
    );

    // 100 MHz forwarded clock that can be parked low.
    initial begin
        forever begin
            #5;
            if (clk_run) fwd_clk = ~fwd_clk;
            else         fwd_clk = 1'b0;
        end
    end

    // 400 MHz monitor clock, offset so its edges never meet fwd_clk edges.
    initial begin
        #0.625;
        forever #1.25 mon_clk = ~mon_clk;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Put one half of both channels' words on the lanes.
    task automatic put_half(input logic [W-1:0] wi, input logic [W-1:0] wq, input bit odd);
        for (int k = 0; k < LANES; k++) begin
            lanes[k]         = odd ? wi[2*k+1] : wi[2*k];
            lanes[LANES + k] = odd ? wq[2*k+1] : wq[2*k];
        end
    endtask

    // Called just after a rising edge; returns 2 ns after the completing edge.
    task automatic drive_word(input logic [W-1:0] wi, input logic [W-1:0] wq, input logic tw);
        twos_comp_en = tw;
        put_half(wi, wq, 1'b1);
        @(negedge fwd_clk);
        #1;
        put_half(wi, wq, 1'b0);
        @(posedge fwd_clk);
        #2;
    endtask

    task automatic check_word(input logic [W-1:0] wi, input logic [W-1:0] wq, input logic tw,
                              input string tag);
        logic [W-1:0] mask;
        mask = {tw, {(W-1){1'b0}}};
        check({tag, " R1 R3 word I"}, 32'(sample_word[W-1:0]), 32'(wi ^ mask));
        check({tag, " R2 R3 word Q"}, 32'(sample_word[2*W-1:W]), 32'(wq ^ mask));
        check({tag, " R4 over"}, 32'(over_range), {30'b0, wq == '1, wi == '1});
        check({tag, " R4 under"}, 32'(under_range), {30'b0, wq == '0, wi == '0});
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #500000;
        if (!done) begin
            n_err++;
            n_checks++;
            $display("FAIL R5 watchdog: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        // Reset state (R6, R7).
        repeat (4) @(posedge fwd_clk);
        #2;
        check("R6 reset word", sample_word, 32'h0);
        check("R6 reset valid", 32'(sample_valid), 32'h0);
        check("R6 reset flags", 32'({over_range, under_range}), 32'h0);
        check("R7 reset cal_idle", 32'(cal_idle), 32'h0);

        // Release after a falling edge: first word has no fresh odd half (R6).
        @(negedge fwd_clk);
        #1;
        rst_n = 1'b1;
        @(posedge fwd_clk);
        #2;
        check("R6 no odd half yet valid", 32'(sample_valid), 32'h0);

        // Vector table walked back to back (R1..R5).
        for (int n = 0; n < NVEC; n++) begin
            drive_word(VEC[n][W-1:0], VEC[n][2*W-1:W], VEC[n][2*W]);
            check_word(VEC[n][W-1:0], VEC[n][2*W-1:W], VEC[n][2*W], $sformatf("vec%0d", n));
            check($sformatf("vec%0d R5 valid", n), 32'(sample_valid), 32'h1);
        end
        check("R7 running cal_idle", 32'(cal_idle), 32'h0);

        // Clock stopped but one lane high: no calibration (R7).
        @(negedge fwd_clk);
        #1;
        clk_run = 1'b0;
        lanes   = 16'h0100;
        #200;
        check("R7 lane high blocks cal_idle", 32'(cal_idle), 32'h0);

        // All low: calibration quiet period detected (R7).
        lanes = '0;
        #200;
        check("R7 quiet detected", 32'(cal_idle), 32'h1);

        // Resume: first word suppressed, next one valid (R8).
        clk_run = 1'b1;
        @(posedge fwd_clk);
        #2;
        check("R8 first word after resume valid", 32'(sample_valid), 32'h0);
        drive_word(16'h1357, 16'h9BDF, 1'b0);
        check_word(16'h1357, 16'h9BDF, 1'b0, "resume");
        check("R8 second word valid", 32'(sample_valid), 32'h1);
        check("R7 cal_idle cleared", 32'(cal_idle), 32'h0);

        // Reset during streaming clears outputs (R6).
        drive_word(16'hFFFF, 16'h0000, 1'b0);
        rst_n = 1'b0;
        @(posedge fwd_clk);
        #2;
        check("R6 mid reset word", sample_word, 32'h0);
        check("R6 mid reset valid", 32'(sample_valid), 32'h0);
        check("R6 mid reset flags", 32'({over_range, under_range}), 32'h0);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule